// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator

This block is a register-mapped pseudo-random number source on a simple 32-bit word bus. Software loads five 32-bit seed words, then writes the control register with the engine-select bit and the start bit both set. If all five seed words have been written at least once since reset, the block runs a 160-bit xorshift generator for five steps, one step per clock. It then copies the resulting five words into read-only output registers and raises a done flag in the status register. Software polls that flag and clears it by writing the status register.

The generator is a controller with three states. `GEN_IDLE` waits for a qualified start. The transition `start` (IDLE to STEP) is taken when a control write arrives with the engine and start bits set while the seeds are complete. `GEN_STEP` advances the state once per cycle. The transition `last_step` (STEP to COMMIT) is taken when the step counter reaches the final word. `GEN_COMMIT` latches the outputs and sets the done flag. The transition `finish` (COMMIT to IDLE) is unconditional. Busy is reported whenever the controller is not in `GEN_IDLE`.

The generator state is loaded one word at a time from the seed writes, and it carries over from run to run. Without new seeds, each run continues the sequence. Writing a seed word between runs replaces that word of the state.

Top module: `prng_periph`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00000001 (only bit 0, buffer ready), all five output words read 0, and every seed-written flag is clear.
- R2: The decoded byte offsets are: control 0x000, status 0x010, seed word n at 0x140+4n, output word n at 0x160+4n (n = 0..4). Reads of any other offset, unaligned ones included, return 0. Writes to any other offset change nothing that can be read.
- R3: Seed offsets read as 0. Writes to output offsets leave the output words unchanged.
- R4: Status bit 1 (seeds complete) reads 1 exactly when all five seed words have been written since reset, and it stays 1 until the next reset.
- R5: A run starts only when all three of these hold: a control write has bit 3 (engine select) = 1, the same write has bit 4 (start) = 1, and status bit 1 = 1. Any other control write starts no run and leaves the outputs unchanged.
- R6: After any control write, control reads back the written value with bit 4 forced to 0.
- R7: Status bit 2 (busy) reads 1 on the six cycles that follow a starting control write. On the next cycle busy reads 0 and status bit 5 (generation done) reads 1.
- R8: A run applies five steps to the state words s0..s4, with s0 the oldest word: t = s0 ^ (s0 >> 2), new = s4 ^ (s4 << 4) ^ t ^ (t << 1), then shift s0 <- s1 ... s3 <- s4, s4 <- new. Output word n then equals state word s(n).
- R9: While busy, the output words read their values from before the run.
- R10: A status write replaces bits 5, 4 and 3 with the written bits. Bit 7 stays 0, bit 0 stays 1, and bits 2 and 1 keep reflecting busy and seed completion.
- R11: The state carries over between runs. A seed write to word n while idle replaces state word s(n) for the next run, and the seed flags stay set.
- R12: While busy, control writes start no new run, and seed writes do not alter the running state (they still set their seed flag).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read (qualified by bus_sel) |
| bus_addr | input | 9 | Byte offset inside the 0x200 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current offset |

## Verification
The checker assumes that a write occupies exactly one cycle, with its data valid in that cycle, so that any rise of busy can be traced to the previous cycle's control write. It also assumes that software never writes the status register in the cycle in which a run commits, because the hardware set of the done flag takes priority there. The stimulus issues one access per clock, drops the strobe between accesses, and does not write status until busy has been seen low.

// File: rtl/prng_pkg.sv
package prng_pkg;

    localparam int unsigned WORD_W = 32;

    // control bits
    localparam int unsigned CTL_ENGINE = 3;
    localparam int unsigned CTL_START  = 4;

    // status bits
    localparam int unsigned STS_ERROR     = 7;
    localparam int unsigned STS_GEN_DONE  = 5;
    localparam int unsigned STS_MSG_DONE  = 4;
    localparam int unsigned STS_PART_DONE = 3;
    localparam int unsigned STS_BUSY      = 2;
    localparam int unsigned STS_SEEDS_OK  = 1;
    localparam int unsigned STS_BUF_READY = 0;

    typedef enum logic [1:0] {
        GEN_IDLE   = 2'd0,
        GEN_STEP   = 2'd1,
        GEN_COMMIT = 2'd2
    } gen_state_e;

endpackage

// File: rtl/prng_seed_track.sv
module prng_seed_track #(
    parameter int unsigned N_WORDS = 5,
    localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_we,
    input  logic [IDX_W-1:0] seed_idx,
    output logic             all_seeded
);

    logic [N_WORDS-1:0] seen_q;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q[g] <= 1'b0;
            end else if (seed_we && (seed_idx == IDX_W'(g))) begin
                seen_q[g] <= 1'b1;
            end
        end
    end

    assign all_seeded = &seen_q;

endmodule

// File: rtl/prng_xorshift_core.sv
module prng_xorshift_core
    import prng_pkg::*;
#(
    parameter int unsigned N_WORDS = 5,
    parameter int unsigned W       = 32,
    parameter int unsigned SH_A    = 2,
    parameter int unsigned SH_B    = 1,
    parameter int unsigned SH_C    = 4,
    localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               load_we,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic [W-1:0]       load_data,
    output logic               busy,
    output logic               commit,
    output logic [N_WORDS*W-1:0] out_flat
);

    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(N_WORDS - 1);

    gen_state_e st_q, st_d;
    logic       step_en;

    logic [IDX_W-1:0] step_cnt_q;
    logic [W-1:0]     words_q [N_WORDS];
    logic [W-1:0]     out_q   [N_WORDS];
    logic [W-1:0]     mix_t;
    logic [W-1:0]     new_word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GEN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and controller outputs
    always_comb begin
        st_d    = st_q;
        busy    = 1'b1;
        step_en = 1'b0;
        commit  = 1'b0;
        unique case (st_q)
            GEN_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    st_d = GEN_STEP;          // start
                end
            end
            GEN_STEP: begin
                step_en = 1'b1;
                if (step_cnt_q == LAST_STEP) begin
                    st_d = GEN_COMMIT;        // last_step
                end
            end
            GEN_COMMIT: begin
                commit = 1'b1;
                st_d   = GEN_IDLE;            // finish
            end
            default: begin
                st_d = GEN_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt_q <= '0;
        end else if (step_en && (step_cnt_q != LAST_STEP)) begin
            step_cnt_q <= step_cnt_q + 1'b1;
        end else begin
            step_cnt_q <= '0;
        end
    end

    // one xorshift step
    always_comb begin
        mix_t    = words_q[0] ^ (words_q[0] >> SH_A);
        new_word = words_q[N_WORDS-1] ^ (words_q[N_WORDS-1] << SH_C)
                 ^ mix_t ^ (mix_t << SH_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (step_en) begin
            for (int i = 0; i < N_WORDS - 1; i++) begin
                words_q[i] <= words_q[i+1];
            end
            words_q[N_WORDS-1] <= new_word;
        end else if (load_we && (st_q == GEN_IDLE)) begin
            words_q[load_idx] <= load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) begin
                out_q[i] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < N_WORDS; i++) begin
                out_q[i] <= words_q[i];
            end
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_out
        assign out_flat[g*W +: W] = out_q[g];
    end

endmodule

// File: rtl/prng_periph.sv
module prng_periph
    import prng_pkg::*;
#(
    parameter int unsigned N_WORDS = 5,
    parameter int unsigned ADDR_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] OFF_SEED  = ADDR_W'(320);
    localparam logic [ADDR_W-1:0] OFF_OUT   = ADDR_W'(352);
    localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(4 * N_WORDS);
    localparam logic [WORD_W-1:0] START_MASK = WORD_W'(1) << CTL_START;

    logic wr_en;
    logic aligned;
    logic ctrl_hit, stat_hit, seed_hit, out_hit;
    logic [ADDR_W-1:0] seed_off, out_off;
    logic [IDX_W-1:0]  seed_idx, out_idx;

    logic [WORD_W-1:0] ctrl_q;
    logic gen_done_q, msg_done_q, part_done_q;
    logic seeds_ok, busy, commit, start_go;
    logic [N_WORDS*WORD_W-1:0] out_flat;
    logic [WORD_W-1:0] status_w;

    // address decode
    assign wr_en    = bus_sel & bus_we;
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign ctrl_hit = (bus_addr == OFF_CTRL);
    assign stat_hit = (bus_addr == OFF_STAT);
    assign seed_off = bus_addr - OFF_SEED;
    assign out_off  = bus_addr - OFF_OUT;
    assign seed_hit = aligned && (bus_addr >= OFF_SEED) && (seed_off < BANK_SPAN);
    assign out_hit  = aligned && (bus_addr >= OFF_OUT) && (out_off < BANK_SPAN);
    assign seed_idx = seed_off[IDX_W+1:2];
    assign out_idx  = out_off[IDX_W+1:2];

    assign start_go = wr_en && ctrl_hit && bus_wdata[CTL_ENGINE]
                    && bus_wdata[CTL_START] && seeds_ok && !busy;

    prng_seed_track #(.N_WORDS(N_WORDS)) u_seed_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_we    (wr_en && seed_hit),
        .seed_idx   (seed_idx),
        .all_seeded (seeds_ok)
    );

    prng_xorshift_core #(.N_WORDS(N_WORDS), .W(WORD_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_go),
        .load_we   (wr_en && seed_hit),
        .load_idx  (seed_idx),
        .load_data (bus_wdata),
        .busy      (busy),
        .commit    (commit),
        .out_flat  (out_flat)
    );

    // control register: start bit never held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && ctrl_hit) begin
            ctrl_q <= bus_wdata & ~START_MASK;
        end
    end

    // software-writable done flags; hardware set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_done_q  <= 1'b0;
            msg_done_q  <= 1'b0;
            part_done_q <= 1'b0;
        end else begin
            if (wr_en && stat_hit) begin
                gen_done_q  <= bus_wdata[STS_GEN_DONE];
                msg_done_q  <= bus_wdata[STS_MSG_DONE];
                part_done_q <= bus_wdata[STS_PART_DONE];
            end
            if (commit) begin
                gen_done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        status_w                = '0;
        status_w[STS_ERROR]     = 1'b0;
        status_w[STS_GEN_DONE]  = gen_done_q;
        status_w[STS_MSG_DONE]  = msg_done_q;
        status_w[STS_PART_DONE] = part_done_q;
        status_w[STS_BUSY]      = busy;
        status_w[STS_SEEDS_OK]  = seeds_ok;
        status_w[STS_BUF_READY] = 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) begin
            bus_rdata = ctrl_q;
        end else if (stat_hit) begin
            bus_rdata = status_w;
        end else if (out_hit) begin
            bus_rdata = out_flat[out_idx*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/prng_periph_chk.sv
module prng_periph_chk #(
    parameter int unsigned N_WORDS = 5,
    parameter int unsigned OUT_W   = 160
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             wr_engine,
    input logic             wr_start,
    input logic             seeds_ok,
    input logic             busy,
    input logic             gen_done,
    input logic [OUT_W-1:0] out_flat
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    AST_SEEDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seeds_ok |=> seeds_ok);                                               // R4

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr && wr_engine && wr_start && seeds_ok)); // R5

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> gen_done);                                            // R7

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < N_WORDS + 1));                                   // R7

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(out_flat));                         // R9

endmodule

bind prng_periph prng_periph_chk #(
    .N_WORDS (N_WORDS),
    .OUT_W   (N_WORDS * 32)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_en && ctrl_hit),
    .wr_engine (bus_wdata[3]),
    .wr_start  (bus_wdata[4]),
    .seeds_ok  (seeds_ok),
    .busy      (busy),
    .gen_done  (gen_done_q),
    .out_flat  (out_flat)
);

// File: tb/prng_periph_bench.sv
`timescale 1ns/1ps
module prng_periph_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    prng_periph u_prng_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // reference model
    logic [31:0] m_ctrl;
    bit          m_done, m_msg, m_part;
    bit [4:0]    m_flags;
    logic [31:0] m_state [5];
    logic [31:0] m_out   [5];
    int          m_busy;

    task automatic model_reset();
        m_ctrl = 0; m_done = 0; m_msg = 0; m_part = 0; m_flags = 0; m_busy = 0;
        for (int i = 0; i < 5; i++) begin m_state[i] = 0; m_out[i] = 0; end
    endtask

    function automatic logic [31:0] m_status();
        return {24'd0, 2'b00, m_done, m_msg, m_part, (m_busy > 0), (&m_flags), 1'b1};
    endfunction

    function automatic logic [31:0] model_read(input logic [8:0] a);
        if (a == 9'h000) return m_ctrl;
        if (a == 9'h010) return m_status();
        for (int k = 0; k < 5; k++) if (a == 9'h160 + 9'(4*k)) return m_out[k];
        return 32'd0;
    endfunction

    task automatic advance();
        for (int s = 0; s < 5; s++) begin
            logic [31:0] t, nv;
            t  = m_state[0] ^ (m_state[0] >> 2);
            nv = m_state[4] ^ (m_state[4] << 4) ^ t ^ (t << 1);
            for (int i = 0; i < 4; i++) m_state[i] = m_state[i+1];
            m_state[4] = nv;
        end
    endtask

    task automatic model_edge(input bit we, input logic [8:0] a, input logic [31:0] d);
        bit was_busy, seeded, fin;
        was_busy = (m_busy > 0);
        seeded   = &m_flags;
        fin      = 0;
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) fin = 1;
        end
        if (we) begin
            if (a == 9'h000) begin
                m_ctrl = d & ~32'h10;
                if (!was_busy && seeded && d[3] && d[4]) begin
                    advance();
                    m_busy = 6;
                end
            end else if (a == 9'h010) begin
                m_done = d[5]; m_msg = d[4]; m_part = d[3];
            end else begin
                for (int k = 0; k < 5; k++) begin
                    if (a == 9'h140 + 9'(4*k)) begin
                        m_flags[k] = 1'b1;
                        if (!was_busy) m_state[k] = d;
                    end
                end
            end
        end
        if (fin) begin
            for (int i = 0; i < 5; i++) m_out[i] = m_state[i];
            m_done = 1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [8:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_read(a));
        @(posedge clk);
        model_edge(0, a, 32'd0);
        #1 bus_sel = 0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge(1, a, d);
        #1 bus_sel = 0; bus_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic read_all_out(input string tag);
        for (int k = 0; k < 5; k++) rd(9'h160 + 9'(4*k), tag);
    endtask

    // poll status until idle, comparing every cycle
    task automatic poll_run(input string tag);
        for (int c = 0; c < 8; c++) rd(9'h010, tag);
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1: literal reset values
        @(negedge clk); bus_addr = 9'h000; #1 chk("R1 ctrl", bus_rdata, 32'h0);
        bus_addr = 9'h010; #1 chk("R1 status", bus_rdata, 32'h1);
        for (int k = 0; k < 5; k++) begin
            bus_addr = 9'h160 + 9'(4*k); #1 chk("R1 out", bus_rdata, 32'h0);
        end

        // R2: undecoded and unaligned offsets
        rd(9'h020, "R2 hole");
        rd(9'h1fc, "R2 top");
        rd(9'h012, "R2 unaligned");
        wr(9'h020, 32'hffff_ffff);
        wr(9'h142, 32'h1234_5678);
        rd(9'h000, "R2 ctrl after stray");
        rd(9'h010, "R2 status after stray");

        // R3: seeds write-only, outputs read-only
        wr(9'h160, 32'hdead_beef);
        rd(9'h160, "R3 out ro");
        wr(9'h140, 32'h0000_0001);
        rd(9'h140, "R3 seed wo");

        // R4/R5/R6: incomplete seeds
        wr(9'h000, 32'h0000_0018);
        rd(9'h000, "R6 start cleared");
        rd(9'h010, "R5 no run without seeds");
        wr(9'h144, 32'h0000_0002);
        wr(9'h148, 32'h0000_0003);
        wr(9'h14c, 32'h0000_0004);
        rd(9'h010, "R4 four seeds");
        wr(9'h150, 32'h0000_0005);
        rd(9'h010, "R4 all seeds");
        chk("R4 bit1 literal", bus_rdata & 32'h2, 32'h2);

        wr(9'h000, 32'h0000_0010);
        rd(9'h010, "R5 start without engine");
        wr(9'h000, 32'h0000_0008);
        rd(9'h010, "R5 engine without start");
        wr(9'h000, 32'hffff_ffff);
        rd(9'h000, "R6 readback");
        chk("R6 literal", bus_rdata, 32'hffff_ffef);

        // R7/R8/R9: first run (started by the all-ones write above)
        rd(9'h160, "R9 out during busy");
        poll_run("R7 busy window");
        read_all_out("R8 first run");

        // R10: status write mask
        wr(9'h010, 32'h0000_0000);
        rd(9'h010, "R10 clear done");
        wr(9'h010, 32'hffff_ffff);
        rd(9'h010, "R10 set masked");
        chk("R10 literal", bus_rdata, 32'h0000_003b);
        wr(9'h010, 32'h0000_0000);

        // R11: continue without new seeds, then with one new seed
        wr(9'h000, 32'h0000_0018);
        poll_run("R7 second run");
        read_all_out("R11 continued");
        wr(9'h148, 32'hcafe_f00d);
        wr(9'h000, 32'h0000_0018);
        // R12: retrigger and seed write during busy are ignored
        wr(9'h000, 32'h0000_0018);
        wr(9'h150, 32'h5555_aaaa);
        rd(9'h164, "R9 out held");
        poll_run("R12 single run");
        read_all_out("R12 state unaffected");
        rd(9'h010, "R12 idle after run");

        // R1/R4: reset again clears flags and outputs
        do_reset();
        rd(9'h010, "R1 status after reset");
        read_all_out("R1 out after reset");
        wr(9'h000, 32'h0000_0018);
        rd(9'h010, "R4 flags cleared by reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule